// File: doc/BRIEF.md
# Output Macrocell for a Sum-of-Products Logic Array

This block is one output cell of a programmable array-logic device. It receives the product terms produced for its pin by the AND array, and it ORs them into a single sum. The cell then either drives that sum straight to the pin or passes it through a D flip-flop clocked by the shared clock pin. It also returns a feedback bit to the array.

Three configuration bits choose the cell's personality. Two are global: `cfg_sync` and `cfg_cplx` are shared by every cell of the device. One is local: `cfg_local` belongs to this cell. Together they select one of four modes: dedicated input, always-driven combinational output, combinational I/O and registered output. The mode steers four selections inside the cell: the output-enable source, the data source, the feedback source and the number of product terms in the sum. A separate polarity bit inverts the pin data when it is clear.

The flip-flop is cleared by an asynchronous power-up reset. A preload strobe can load it directly for test.

Top module: `pal_out_cell`

## Requirements
- R1: The mode follows this table. With `cfg_sync`=1, `cfg_local`=0 selects registered and `cfg_local`=1 selects combinational I/O; `cfg_cplx` has no effect. With `cfg_sync`=0 and `cfg_cplx`=1, the mode is combinational I/O whatever `cfg_local` is. With `cfg_sync`=0 and `cfg_cplx`=0, `cfg_local`=1 selects dedicated input and `cfg_local`=0 selects combinational output.
- R2: On each rising `clk` edge without preload, the flip-flop captures the OR of all `N_PT` product terms. In registered mode the pin data is the flip-flop value, and `fb` is its complement.
- R3: In registered mode `pin_oe` is the inverse of the active-low `oe_n_pin`.
- R4: In combinational I/O mode `pin_oe` equals `pterm[0]`. The pin data is the OR of `pterm[N_PT-1:1]`, `fb` equals `pin_in`, and `oe_n_pin` has no effect.
- R5: In combinational output mode `pin_oe` is 1 and the pin data is the OR of all `N_PT` terms. `fb` equals `pin_in`, and `oe_n_pin` has no effect.
- R6: In dedicated input mode `pin_oe` is 0 and `fb` equals `pin_in`.
- R7: When `pol_high` is 1 the pin data is driven true; when it is 0 the pin data is driven inverted. `fb` is not affected by polarity.
- R8: While `rst_n` is low the flip-flop is 0, independent of the clock. In registered mode this gives `fb`=1 and pin data equal to `~pol_high`.
- R9: When `pload` is high at a rising `clk` edge, the flip-flop takes `pload_d` in place of the product-term sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock pin |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| cfg_sync | input | 1 | Global mode bit (registered device) |
| cfg_cplx | input | 1 | Global mode bit (complex I/O) |
| cfg_local | input | 1 | Per-cell mode bit |
| pol_high | input | 1 | 1: active-high pin data, 0: active-low |
| pterm | input | N_PT | Product terms from the AND array |
| oe_n_pin | input | 1 | Shared active-low output-enable pin |
| pin_in | input | 1 | Value present on the I/O pin |
| pload | input | 1 | Preload strobe for the flip-flop |
| pload_d | input | 1 | Preload data |
| pin_out | output | 1 | Pin data to the output driver |
| pin_oe | output | 1 | Output driver enable; 0 tri-states the pin |
| fb | output | 1 | Feedback bit to the AND array |

## Verification
The bench builds the cell with the default `N_PT` of 8. At that width all 256 product-term patterns can be swept under each of the eight configuration-bit combinations and both polarities. This covers the case where `pterm[0]` alone gates the driver while the other seven terms are zero, and the all-ones pattern that preload must override. Mid-run resets and preloads against opposite sums cover the flip-flop corner cases.

// File: rtl/pal_out_cell.sv
module pal_out_cell #(
  parameter int N_PT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_sync,
  input  logic            cfg_cplx,
  input  logic            cfg_local,
  input  logic            pol_high,
  input  logic [N_PT-1:0] pterm,
  input  logic            oe_n_pin,
  input  logic            pin_in,
  input  logic            pload,
  input  logic            pload_d,
  output logic            pin_out,
  output logic            pin_oe,
  output logic            fb
);
  localparam int N_DATA = N_PT - 1;

  typedef enum logic [1:0] {M_DIN, M_COUT, M_CIO, M_REG} mode_e;

  mode_e mode;
  logic  q;
  logic  sum_all;
  logic  sum_data;
  logic  raw;
  logic  [N_DATA-1:0] data_terms;

  always_comb begin
    if (cfg_sync)      mode = cfg_local ? M_CIO : M_REG;
    else if (cfg_cplx) mode = M_CIO;
    else               mode = cfg_local ? M_DIN : M_COUT;
  end

  assign data_terms = pterm[N_PT-1:1];
  assign sum_all    = |pterm;
  assign sum_data   = |data_terms;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (pload) q <= pload_d;
    else            q <= sum_all;
  end

  assign raw     = (mode == M_REG) ? q : (mode == M_CIO) ? sum_data : sum_all;
  assign pin_out = pol_high ? raw : ~raw;
  assign fb      = (mode == M_REG) ? ~q : pin_in;

  always_comb begin
    case (mode)
      M_REG:   pin_oe = ~oe_n_pin;
      M_CIO:   pin_oe = pterm[0];
      M_COUT:  pin_oe = 1'b1;
      default: pin_oe = 1'b0;
    endcase
  end

  assert_preload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pload |=> q == $past(pload_d));

  assert_reg_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pload) |=> (mode != M_REG) || (fb == !$past(|pterm)));

  assert_din_tristate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DIN) |-> (!pin_oe && fb == pin_in));

  assert_cio_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_CIO) |-> (pin_oe == pterm[0] && fb == pin_in));

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n |-> q == 1'b0);
endmodule

// File: tb/pal_out_cell_tb_top.sv
`timescale 1ns/1ps
module pal_out_cell_tb_top;
  localparam int N_PT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sync = 1'b1, cfg_cplx = 1'b0, cfg_local = 1'b0, pol_high = 1'b1;
  logic [N_PT-1:0] pterm = '0;
  logic oe_n_pin = 1'b0, pin_in = 1'b0, pload = 1'b0, pload_d = 1'b0;
  logic pin_out, pin_oe, fb;

  int total = 0;
  int bad = 0;
  logic q_m = 1'b0;

  typedef struct {
    logic out;
    logic oe;
    logic fbv;
    logic chk_out;
    int   tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  pal_out_cell #(.N_PT(N_PT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_cplx(cfg_cplx),
    .cfg_local(cfg_local), .pol_high(pol_high), .pterm(pterm),
    .oe_n_pin(oe_n_pin), .pin_in(pin_in), .pload(pload), .pload_d(pload_d),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  function automatic string tag_name(int t);
    case (t)
      2: return "R1,R2,R3";
      4: return "R1,R4";
      5: return "R1,R5";
      6: return "R1,R6";
      9: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual out/oe/fb=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic step(logic g0, logic g1, logic loc, logic pol, logic [N_PT-1:0] pt,
                      logic oen, logic pin, logic pl, logic pld);
    exp_t e;
    int   md;
    logic val;
    @(negedge clk);
    cfg_sync = g0; cfg_cplx = g1; cfg_local = loc; pol_high = pol;
    pterm = pt; oe_n_pin = oen; pin_in = pin; pload = pl; pload_d = pld;
    if (g0)      md = loc ? 4 : 2;
    else if (g1) md = 4;
    else         md = loc ? 6 : 5;
    q_m = pl ? pld : |pt;
    case (md)
      2: begin val = q_m;      e.oe = ~oen;  e.fbv = ~q_m; end
      4: begin val = |pt[7:1]; e.oe = pt[0]; e.fbv = pin;  end
      5: begin val = |pt;      e.oe = 1'b1;  e.fbv = pin;  end
      default: begin val = 1'b0; e.oe = 1'b0; e.fbv = pin; end
    endcase
    e.out     = pol ? val : ~val;
    e.chk_out = e.oe;
    e.tag     = (pl && md == 2) ? 9 : md;
    sb.push_back(e);
  endtask

  always begin
    @(posedge clk);
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      string req;
      e = sb.pop_front();
      req = tag_name(e.tag);
      if (!pol_high) req = {req, ",R7"};
      check(req, {e.chk_out ? pin_out : 1'b0, pin_oe, fb},
                 {e.chk_out ? e.out : 1'b0, e.oe, e.fbv});
    end
  end

  task automatic reset_check(logic pol);
    @(negedge clk);
    cfg_sync = 1'b1; cfg_cplx = 1'b0; cfg_local = 1'b0; pol_high = pol;
    oe_n_pin = 1'b0; pterm = '1; pload = 1'b0;
    rst_n = 1'b0;
    q_m = 1'b0;
    #1;
    check("R8", {pin_out, pin_oe, fb}, {~pol, 1'b1, 1'b1});
    @(posedge clk);
    #5;
    check("R8", {pin_out, pin_oe, fb}, {~pol, 1'b1, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1;
    check("R8", {pin_out, pin_oe, fb}, {1'b0, 1'b1, 1'b1});
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int m = 0; m < 8; m++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int p = 0; p < 256; p++) begin
          logic [7:0] pv;
          pv = p[7:0];
          step(m[2], m[1], m[0], pol[0], pv, pv[3] ^ pv[5], pv[1] ^ pv[6],
               (p % 11) == 5, pv[2]);
        end
      end
    end

    // R9: preload against an opposite sum in both directions
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    // R3: global OE high tri-states the registered pin
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h10, 1'b1, 1'b1, 1'b0, 1'b0);
    // R4: only pterm[0] set, the driver is on with zero data
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);

    reset_check(1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0);
    reset_check(1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule